// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block sequences a successive-approximation analog-to-digital converter. A host drives an enable, a start strobe, an auto-trigger enable, a free-running mode select, an interrupt enable and a flag-clear strobe, and also presents the desired channel/reference selection. The block keeps a working copy of that selection and passes it to the analog front end. The working copy is frozen while a conversion runs, so the sampling window always sees a steady input. It reopens during the last ADC clock of the conversion.

The sequencer runs on a clock at twice the ADC clock rate, so every timing point falls on a clock edge. All counts are in half ADC cycles. Three conversion kinds have their own length and sample-and-hold position: the first conversion after enabling, a normal conversion, and a trigger-started conversion. Each conversion raises a sample-and-hold strobe at its sample point. At completion it captures the converter's result, sets a sticky done flag and, if the interrupt enable is set, raises an interrupt request. In free-running mode a new normal conversion begins on the clock right after each completion.

Top module: `adc_seq_top`

## Requirements
- R1: When the selection is not frozen, including while `en` is low, `sel_out` takes the value of `host_sel` one clock later.
- R2: From the clock after a conversion begins until two clocks before it ends, `sel_out` holds the value captured at the start edge. In the last two clocks (one ADC cycle) it follows `host_sel` again.
- R3: A start request is taken at a clock edge while `en` is high. The conversion begins at the first later enabled edge whose index is even, counting enabled edges from 0 after `en` rises. Even indices are the rising ADC clock edges.
- R4: The first conversion after `en` rises lasts 50 clocks. `sh_strobe` is high in the cycle after the 27th clock following the start edge.
- R5: A normal conversion lasts 26 clocks, with `sh_strobe` at position 3.
- R6: With `auto_en` high and `free_run` low, a rising edge of `trig_in` acts as a start request. The conversion then lasts 27 clocks, with `sh_strobe` at position 4. With `auto_en` low, `trig_in` has no effect.
- R7: `busy` is high from the edge that takes a start request until the completion edge. After reset, `busy`, `sh_strobe`, `done_flag`, `irq`, `sel_out` and `result_out` are zero.
- R8: At completion `done_flag` is set and `result_out` captures `result_in`. The flag stays set until a clock with `flag_clr` high clears it, and setting takes priority over clearing.
- R9: `irq` is high exactly while `done_flag` and `ie` are both high.
- R10: In free-running mode the next normal conversion starts on the completion edge. A selection written after the done flag is seen applies only to the conversion after the one already started.
- R11: Dropping `en` aborts any conversion, so `busy` is low after the next clock. The next conversion after re-enabling is a first conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the ADC clock rate |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Converter enable |
| host_sel | input | SEL_W | Host-written channel/reference selection |
| start_wr | input | 1 | One-clock start strobe |
| auto_en | input | 1 | Auto-trigger enable |
| free_run | input | 1 | Free-running mode select |
| trig_in | input | 1 | External trigger source |
| ie | input | 1 | Interrupt enable |
| flag_clr | input | 1 | One-clock done-flag clear strobe |
| result_in | input | RES_W | Converter result, sampled at completion |
| sel_out | output | SEL_W | Working selection to the analog front end |
| sh_strobe | output | 1 | Sample-and-hold strobe |
| busy | output | 1 | Start bit readback, high while pending or converting |
| done_flag | output | 1 | Sticky conversion-complete flag |
| irq | output | 1 | Interrupt request |
| result_out | output | RES_W | Result captured at completion |

## Verification
The hardest situation to reach from the ports is the selection handoff across a free-running restart. A host write that lands just after the done flag rises must miss the conversion that has already begun and reach only the one after it. The bench gets there by keeping a start in free-running mode and changing `host_sel` twice: once during the first conversion, and once on the cycle the flag is first seen. It then checks which value each conversion holds, clock by clock. Start alignment to the rising ADC edge is covered by sweeping the request offset over both clock phases for each of the three conversion kinds. The bench tracks enabled edges itself, so it can predict every strobe and completion cycle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        CK_FIRST = 2'd0,
        CK_NORM  = 2'd1,
        CK_AUTO  = 2'd2
    } conv_kind_e;

    // Timing in half ADC cycles (clock runs at twice the ADC clock)
    localparam int DEF_LEN_FIRST = 50;
    localparam int DEF_SH_FIRST  = 27;
    localparam int DEF_LEN_NORM  = 26;
    localparam int DEF_SH_NORM   = 3;
    localparam int DEF_LEN_AUTO  = 27;
    localparam int DEF_SH_AUTO   = 4;

    function automatic int pick_by_kind(conv_kind_e k, int v_first, int v_norm, int v_auto);
        case (k)
            CK_FIRST: return v_first;
            CK_AUTO:  return v_auto;
            default:  return v_norm;
        endcase
    endfunction

    function automatic conv_kind_e next_kind(logic first_pend, logic from_trig);
        if (first_pend) return CK_FIRST;
        if (from_trig)  return CK_AUTO;
        return CK_NORM;
    endfunction

endpackage

// File: rtl/adc_seq_trig.sv
module adc_seq_trig (
    input  logic clk,
    input  logic rst,
    input  logic trig_in,
    output logic trig_rise
);
    logic trig_q;

    always_ff @(posedge clk) begin
        if (rst) trig_q <= 1'b0;
        else     trig_q <= trig_in;
    end

    assign trig_rise = trig_in & ~trig_q;
endmodule

// File: rtl/adc_seq_sel.sv
module adc_seq_sel #(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] host_sel,
    input  logic             lock,
    output logic [SEL_W-1:0] sel_work
);
    always_ff @(posedge clk) begin
        if (rst)       sel_work <= '0;
        else if (!lock) sel_work <= host_sel;
    end
endmodule

// File: rtl/adc_seq_core.sv
module adc_seq_core
    import adc_seq_pkg::*;
#(
    parameter int LEN_FIRST = DEF_LEN_FIRST,
    parameter int SH_FIRST  = DEF_SH_FIRST,
    parameter int LEN_NORM  = DEF_LEN_NORM,
    parameter int SH_NORM   = DEF_SH_NORM,
    parameter int LEN_AUTO  = DEF_LEN_AUTO,
    parameter int SH_AUTO   = DEF_SH_AUTO,
    parameter int RES_W     = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             start_wr,
    input  logic             trig_rise,
    input  logic             auto_en,
    input  logic             free_run,
    input  logic             flag_clr,
    input  logic [RES_W-1:0] result_in,
    output logic             busy,
    output logic             running,
    output logic             lock,
    output logic             ph,
    output logic             sh_strobe,
    output logic             done_flag,
    output logic [RES_W-1:0] result_out
);
    localparam int HC_W = $clog2(LEN_FIRST + 1);
    typedef logic [HC_W-1:0] hc_t;

    seq_state_e st;
    conv_kind_e kind;
    hc_t        hc;
    hc_t        last_pos;
    hc_t        sh_pos;
    hc_t        open_pos;
    logic       first_pend;
    logic       pend_auto;
    logic       at_end;
    logic       trig_take;

    always_comb begin
        last_pos = hc_t'(pick_by_kind(kind, LEN_FIRST, LEN_NORM, LEN_AUTO) - 1);
        sh_pos   = hc_t'(pick_by_kind(kind, SH_FIRST, SH_NORM, SH_AUTO));
        open_pos = last_pos - hc_t'(1);
    end

    assign running   = (st == ST_RUN);
    assign busy      = (st != ST_IDLE);
    assign lock      = running && (hc < open_pos);
    assign sh_strobe = running && (hc == sh_pos);
    assign at_end    = running && en && (hc == last_pos);
    assign trig_take = trig_rise && auto_en && !free_run;

    // Done flag and result capture
    always_ff @(posedge clk) begin
        if (rst) begin
            done_flag  <= 1'b0;
            result_out <= '0;
        end else if (at_end) begin
            done_flag  <= 1'b1;
            result_out <= result_in;
        end else if (flag_clr) begin
            done_flag  <= 1'b0;
        end
    end

    // Sequencing state
    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            kind       <= CK_NORM;
            hc         <= '0;
            ph         <= 1'b0;
            first_pend <= 1'b1;
            pend_auto  <= 1'b0;
        end else if (!en) begin
            st         <= ST_IDLE;
            hc         <= '0;
            ph         <= 1'b0;
            first_pend <= 1'b1;
            pend_auto  <= 1'b0;
        end else begin
            ph <= ~ph;
            case (st)
                ST_IDLE: begin
                    if (start_wr) begin
                        st        <= ST_WAIT;
                        pend_auto <= 1'b0;
                    end else if (trig_take) begin
                        st        <= ST_WAIT;
                        pend_auto <= 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (!ph) begin
                        st         <= ST_RUN;
                        hc         <= '0;
                        kind       <= next_kind(first_pend, pend_auto);
                        first_pend <= 1'b0;
                    end
                end
                ST_RUN: begin
                    if (hc == last_pos) begin
                        if (free_run) begin
                            hc   <= '0;
                            kind <= CK_NORM;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end else begin
                        hc <= hc + hc_t'(1);
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
    import adc_seq_pkg::*;
#(
    parameter int SEL_W     = 4,
    parameter int RES_W     = 10,
    parameter int LEN_FIRST = DEF_LEN_FIRST,
    parameter int SH_FIRST  = DEF_SH_FIRST,
    parameter int LEN_NORM  = DEF_LEN_NORM,
    parameter int SH_NORM   = DEF_SH_NORM,
    parameter int LEN_AUTO  = DEF_LEN_AUTO,
    parameter int SH_AUTO   = DEF_SH_AUTO
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [SEL_W-1:0] host_sel,
    input  logic             start_wr,
    input  logic             auto_en,
    input  logic             free_run,
    input  logic             trig_in,
    input  logic             ie,
    input  logic             flag_clr,
    input  logic [RES_W-1:0] result_in,
    output logic [SEL_W-1:0] sel_out,
    output logic             sh_strobe,
    output logic             busy,
    output logic             done_flag,
    output logic             irq,
    output logic [RES_W-1:0] result_out
);
    logic w_trig_rise;
    logic w_lock;
    logic w_run;
    logic w_ph;

    adc_seq_trig u_trig (
        .clk       (clk),
        .rst       (rst),
        .trig_in   (trig_in),
        .trig_rise (w_trig_rise)
    );

    adc_seq_core #(
        .LEN_FIRST (LEN_FIRST),
        .SH_FIRST  (SH_FIRST),
        .LEN_NORM  (LEN_NORM),
        .SH_NORM   (SH_NORM),
        .LEN_AUTO  (LEN_AUTO),
        .SH_AUTO   (SH_AUTO),
        .RES_W     (RES_W)
    ) u_core (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .start_wr   (start_wr),
        .trig_rise  (w_trig_rise),
        .auto_en    (auto_en),
        .free_run   (free_run),
        .flag_clr   (flag_clr),
        .result_in  (result_in),
        .busy       (busy),
        .running    (w_run),
        .lock       (w_lock),
        .ph         (w_ph),
        .sh_strobe  (sh_strobe),
        .done_flag  (done_flag),
        .result_out (result_out)
    );

    adc_seq_sel #(
        .SEL_W (SEL_W)
    ) u_sel (
        .clk      (clk),
        .rst      (rst),
        .host_sel (host_sel),
        .lock     (w_lock),
        .sel_work (sel_out)
    );

    assign irq = done_flag & ie;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int SEL_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             flag_clr,
    input logic [SEL_W-1:0] sel_out,
    input logic             busy,
    input logic             sh_strobe,
    input logic             done_flag,
    input logic             lock,
    input logic             running,
    input logic             ph
);
    a_r2_frozen_sel: assert property (@(posedge clk) disable iff (rst)
        lock |=> $stable(sel_out));

    a_r3_start_on_rising: assert property (@(posedge clk) disable iff (rst)
        $rose(running) |-> ($past(ph) == 1'b0));

    a_r5_strobe_in_run: assert property (@(posedge clk) disable iff (rst)
        sh_strobe |-> running);

    a_r7_busy_covers_run: assert property (@(posedge clk) disable iff (rst)
        running |-> busy);

    a_r8_flag_from_run: assert property (@(posedge clk) disable iff (rst)
        $rose(done_flag) |-> $past(running));

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (done_flag && !flag_clr) |=> done_flag);

    a_r11_disable_idles: assert property (@(posedge clk) disable iff (rst)
        !en |=> !busy);
endmodule

bind adc_seq_top adc_seq_chk #(.SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .flag_clr  (flag_clr),
    .sel_out   (sel_out),
    .busy      (busy),
    .sh_strobe (sh_strobe),
    .done_flag (done_flag),
    .lock      (w_lock),
    .running   (w_run),
    .ph        (w_ph)
);

// File: tb/test_adc_seq_top.sv
module test_adc_seq_top;
    localparam int CLK_PERIOD = 10;
    localparam int SW = 4;
    localparam int RW = 10;
    // Expected timing in half ADC cycles
    localparam int LF  = 2 * 25;
    localparam int SHF = 2 * 13 + 1;
    localparam int LN  = 2 * 13;
    localparam int SHN = 2 * 1 + 1;
    localparam int LA  = 2 * 13 + 1;
    localparam int SHA = 2 * 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en = 1'b0;
    logic [SW-1:0] host_sel = '0;
    logic          start_wr = 1'b0;
    logic          auto_en = 1'b0;
    logic          free_run = 1'b0;
    logic          trig_in = 1'b0;
    logic          ie = 1'b0;
    logic          flag_clr = 1'b0;
    logic [RW-1:0] result_in = '0;
    logic [SW-1:0] sel_out;
    logic          sh_strobe;
    logic          busy;
    logic          done_flag;
    logic          irq;
    logic [RW-1:0] result_out;

    int n_chk = 0;
    int n_fail = 0;
    int ecnt = 0;

    adc_seq_top i_adc_seq_top (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .host_sel   (host_sel),
        .start_wr   (start_wr),
        .auto_en    (auto_en),
        .free_run   (free_run),
        .trig_in    (trig_in),
        .ie         (ie),
        .flag_clr   (flag_clr),
        .result_in  (result_in),
        .sel_out    (sel_out),
        .sh_strobe  (sh_strobe),
        .busy       (busy),
        .done_flag  (done_flag),
        .irq        (irq),
        .result_out (result_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Enabled-edge counter: after edge n (0-based) it reads n+1
    always @(posedge clk) begin
        if (!en) ecnt <= 0;
        else     ecnt <= ecnt + 1;
    end

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_conv(string req, int len, int sh, bit use_trig,
                           logic [SW-1:0] nsel, logic [RW-1:0] res);
        int w;
        int k;
        int m;
        logic [SW-1:0] cap;
        @(negedge clk);
        result_in = res;
        cap = host_sel;
        w = ecnt;
        if (use_trig) trig_in = 1'b1;
        else          start_wr = 1'b1;
        k = (w % 2 == 0) ? w + 2 : w + 1;  // R3: first even edge after w
        do begin
            @(negedge clk);
            start_wr = 1'b0;
            trig_in = 1'b0;
            m = ecnt - 1;
            chk("R7", {req, " busy"}, int'(busy), int'(m < k + len));
            chk(req, "sh_strobe", int'(sh_strobe), int'(m == k + sh));
            chk("R8", {req, " done_flag"}, int'(done_flag), int'(m >= k + len));
            if (m >= k && m <= k + len - 2) chk("R2", {req, " sel frozen"}, int'(sel_out), int'(cap));
            if (m >= k + len - 1) chk("R2", {req, " sel reopened"}, int'(sel_out), int'(nsel));
            if (m == k + len) begin
                chk("R8", {req, " result"}, int'(result_out), int'(res));
                chk("R9", {req, " irq"}, int'(irq), int'(ie));
            end
            if (m == k + 2) host_sel = nsel;
        end while (m < k + len);
        @(negedge clk);
        chk("R8", {req, " flag holds"}, int'(done_flag), 1);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        chk("R8", {req, " flag cleared"}, int'(done_flag), 0);
        chk("R9", {req, " irq cleared"}, int'(irq), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R7 watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int w;
        int k;
        int k2;
        int m;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R7", "reset busy", int'(busy), 0);
        chk("R7", "reset flag", int'(done_flag), 0);
        chk("R7", "reset irq", int'(irq), 0);
        chk("R7", "reset sh", int'(sh_strobe), 0);
        chk("R7", "reset sel", int'(sel_out), 0);
        chk("R7", "reset result", int'(result_out), 0);

        // R1: follows while disabled
        host_sel = 4'h5;
        @(negedge clk);
        chk("R1", "sel follows when disabled", int'(sel_out), 5);

        ie = 1'b1;
        // R4: first conversion, offsets across both phases
        for (int off = 0; off < 3; off++) begin
            en = 1'b0;
            repeat (2) @(negedge clk);
            en = 1'b1;
            repeat (off) @(negedge clk);
            do_conv("R4", LF, SHF, 1'b0, SW'(off + 8), RW'(100 + off));
        end

        // R5: normal conversions, offsets 0..3
        for (int off = 0; off < 4; off++) begin
            repeat (off) @(negedge clk);
            do_conv("R5", LN, SHN, 1'b0, SW'(off + 1), RW'(200 + off));
        end

        // R6: trigger-started conversions
        auto_en = 1'b1;
        for (int off = 0; off < 4; off++) begin
            repeat (off) @(negedge clk);
            do_conv("R6", LA, SHA, 1'b1, SW'(off + 12), RW'(300 + off));
        end
        auto_en = 1'b0;

        // R6: trigger ignored when auto-trigger is off
        @(negedge clk);
        trig_in = 1'b1;
        @(negedge clk);
        trig_in = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk("R6", "trigger ignored", int'(busy), 0);
            @(negedge clk);
        end

        // R9: interrupt masked
        ie = 1'b0;
        do_conv("R9", LN, SHN, 1'b0, 4'h7, RW'(511));
        ie = 1'b1;

        // R10: free-running handoff
        free_run = 1'b1;
        @(negedge clk);
        host_sel = 4'h2;
        @(negedge clk);
        w = ecnt;
        start_wr = 1'b1;
        k = (w % 2 == 0) ? w + 2 : w + 1;
        k2 = k + LN;
        do begin
            @(negedge clk);
            start_wr = 1'b0;
            m = ecnt - 1;
            if (m == k + 2) host_sel = 4'h9;
            if (m == k + LN) begin
                chk("R10", "first flag", int'(done_flag), 1);
                chk("R10", "restart busy", int'(busy), 1);
                host_sel = 4'hC;
            end
            if (m == k2 + 2) free_run = 1'b0;
            if (m == k2 + SHN) chk("R10", "restart strobe", int'(sh_strobe), 1);
            if (m == k2 + 5 || m == k2 + LN - 2) chk("R10", "old sel kept", int'(sel_out), 9);
            if (m == k2 + LN - 1) chk("R10", "new sel next", int'(sel_out), 12);
            if (m == k2 + LN) chk("R10", "stops", int'(busy), 0);
        end while (m < k2 + LN);
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;

        // R11: abort and re-enable
        start_wr = 1'b1;
        @(negedge clk);
        start_wr = 1'b0;
        repeat (6) @(negedge clk);
        chk("R11", "busy before abort", int'(busy), 1);
        en = 1'b0;
        @(negedge clk);
        chk("R11", "busy after abort", int'(busy), 0);
        host_sel = 4'h3;
        @(negedge clk);
        chk("R1", "sel while disabled", int'(sel_out), 3);
        chk("R11", "no flag on abort", int'(done_flag), 0);
        en = 1'b1;
        do_conv("R11", LF, SHF, 1'b0, 4'h6, RW'(42));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule